// File: doc/BRIEF.md
# Multi-Queue Packet Ready Tracker

This block watches the word traffic of a shared-memory buffer that holds several logical queues, and keeps a count of whole, delimited packets in each queue. A word written into a queue can carry a start marker and an end marker in its top data bits. A word read from the queue currently selected for reading carries the same markers back. The block does not store data. It tracks which queues have an open packet, how many complete packets each queue holds, and whether the writer follows the rule that it may change queues only between packets.

For the queue selected on the read side, the block drives an active-low ready flag whenever that queue holds at least one complete packet. Two one-cycle error pulses report protocol faults. One fires when the writer changes queue while a packet is still open. The other fires when a start marker arrives in a queue that already has an open packet. Packet operation is chosen once, while reset is held. It is refused unless the port-width configuration reads as full-width on both sides. When packet operation is off, the flag rests high and the almost-empty status elsewhere in the buffer is the status to use.

Top module: `pkt_ready_tracker`

## Requirements
- R1: The packet-mode choice is taken from `pkt_mode_i` on clock edges while `rst_n` is low, and is shown on `pkt_mode_o`. Changes on `pkt_mode_i` after reset has been released have no effect.
- R2: Packet mode is granted only when `port_cfg_i` is 2'b00, which means full-width input and output ports. Any other code turns packet mode off, whatever `pkt_mode_i` holds.
- R3: In both written and read words, bit 32 is the start marker and bit 33 is the end marker. Bits 35:34 and the lower 32 bits have no effect on tracking.
- R4: At each clock edge, `pkt_ready_n_o` is driven low if the read-selected queue's complete-packet count, as it stood after the previous edge, was non-zero. Otherwise it is driven high. A packet completed at edge k therefore shows on the flag after edge k+1.
- R5: A write to a queue other than the last written queue, made while that last queue has an open packet, raises `switch_err_o` for one cycle after that edge.
- R6: With packet mode off, `pkt_ready_n_o` stays high, both error outputs stay low, and markers are ignored.
- R7: A write carrying the end marker completes a packet, and adds one to that queue's count, if that queue had an open packet or the same word also carries the start marker. An end marker with no open packet changes nothing.
- R8: A start marker written to a queue that already has an open packet raises `sop_err_o` for one cycle, and the packet stays open. The next end marker in that queue completes exactly one packet.
- R9: A read carrying the end marker takes one from the count of the read-selected queue. A count of zero stays at zero. If a completing write to the same queue happens in the same cycle, the count is left unchanged.
- R10: Each count saturates at 255. Writes beyond that point leave it at 255.
- R11: The read queue index is loaded from `rd_sel_i` at an edge where `rd_sel_en_i` is high. A read in that same cycle still applies to the previously selected queue.
- R12: After reset, `pkt_ready_n_o` is high, both error outputs are low, every count is zero, no packet is open, and queue 0 is selected on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low master reset; mode is captured while low |
| pkt_mode_i | input | 1 | Requests packet operation, sampled during reset |
| port_cfg_i | input | 2 | Port width code; 2'b00 means full width on both ports |
| wr_en_i | input | 1 | A word is written this cycle |
| wr_q_i | input | 5 | Queue index of the written word |
| wr_data_i | input | 36 | Written word; bit 32 start marker, bit 33 end marker |
| rd_en_i | input | 1 | A word is read from the selected queue this cycle |
| rd_data_i | input | 36 | Read word; same marker positions |
| rd_sel_en_i | input | 1 | Load a new read queue index |
| rd_sel_i | input | 5 | New read queue index |
| pkt_ready_n_o | output | 1 | Low when the read-selected queue holds a complete packet |
| switch_err_o | output | 1 | One-cycle pulse: write queue changed mid-packet |
| sop_err_o | output | 1 | One-cycle pulse: start marker while a packet is open |
| pkt_mode_o | output | 1 | Packet mode in force |

## Verification
The tracker is exercised with multi-word packets and with single words that carry both markers. It also sees interleaved reads from a queue other than the one being written, end markers with no open packet, and words with only the unused upper bits set. These patterns separate counting on packet completion from counting on every marker. Further runs cover a mid-packet queue change, a doubled start marker, and 256 packets into one queue followed by a drain of 254 reads and then one more. Those runs expose missing error pulses, a wrapping counter, and off-by-one latency. Three extra resets cover packet mode refused through the mode input, refused through the width code, and a mode input toggled after reset.

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker #(
  parameter int NQ = 32,
  parameter int DW = 36,
  parameter int CW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_mode_i,
  input  logic [1:0]            port_cfg_i,
  input  logic                  wr_en_i,
  input  logic [$clog2(NQ)-1:0] wr_q_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic                  rd_en_i,
  input  logic [DW-1:0]         rd_data_i,
  input  logic                  rd_sel_en_i,
  input  logic [$clog2(NQ)-1:0] rd_sel_i,
  output logic                  pkt_ready_n_o,
  output logic                  switch_err_o,
  output logic                  sop_err_o,
  output logic                  pkt_mode_o
);
  localparam int QW = $clog2(NQ);
  localparam int SOP_BIT = DW - 4;
  localparam int EOP_BIT = DW - 3;
  localparam logic [CW-1:0] CMAX = '1;

  logic          mode_q;
  logic [CW-1:0] cnt [NQ];
  logic [NQ-1:0] open_q, inc_v, dec_v;
  logic [QW-1:0] wq_last, rsel_q;

  wire wr_act  = mode_q & wr_en_i;
  wire w_sop   = wr_act & wr_data_i[SOP_BIT];
  wire w_eop   = wr_act & wr_data_i[EOP_BIT];
  wire r_eop   = mode_q & rd_en_i & rd_data_i[EOP_BIT];
  wire cur_open = open_q[wr_q_i];
  wire w_done  = w_eop & (cur_open | w_sop);
  wire dup_sop = w_sop & cur_open;
  wire sw_err  = wr_act & (wr_q_i != wq_last) & open_q[wq_last];

  assign pkt_mode_o = mode_q;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      inc_v[q] = w_done && (wr_q_i == QW'(q));
      dec_v[q] = r_eop && (rsel_q == QW'(q)) && (cnt[q] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q        <= pkt_mode_i && (port_cfg_i == 2'b00);
      open_q        <= '0;
      wq_last       <= '0;
      rsel_q        <= '0;
      pkt_ready_n_o <= 1'b1;
      switch_err_o  <= 1'b0;
      sop_err_o     <= 1'b0;
      for (int q = 0; q < NQ; q++) cnt[q] <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (inc_v[q] && !dec_v[q] && cnt[q] != CMAX) cnt[q] <= cnt[q] + 1'b1;
        else if (dec_v[q] && !inc_v[q])              cnt[q] <= cnt[q] - 1'b1;
      end
      if (wr_act) begin
        if (w_eop)      open_q[wr_q_i] <= 1'b0;
        else if (w_sop) open_q[wr_q_i] <= 1'b1;
      end
      if (wr_en_i)     wq_last <= wr_q_i;
      if (rd_sel_en_i) rsel_q  <= rd_sel_i;
      pkt_ready_n_o <= !(mode_q && cnt[rsel_q] != '0);
      switch_err_o  <= sw_err;
      sop_err_o     <= dup_sop;
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q)); // R1
  AST_OFF_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |=> (pkt_ready_n_o && !switch_err_o && !sop_err_o)); // R6
  AST_SWITCH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_err_o |-> $past(wr_en_i)); // R5
  AST_DUP_SOP_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    sop_err_o |-> $past(wr_en_i && wr_data_i[SOP_BIT])); // R8
  AST_READY_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready_n_o |-> mode_q); // R4
endmodule

// File: tb/test_pkt_ready_tracker.sv
module test_pkt_ready_tracker;
  logic clk = 1'b0, rst_n = 1'b0, pkt_mode_i = 1'b1;
  logic [1:0] port_cfg_i = 2'b00;
  logic wr_en_i = 0, rd_en_i = 0, rd_sel_en_i = 0;
  logic [4:0] wr_q_i = '0, rd_sel_i = '0;
  logic [35:0] wr_data_i = '0, rd_data_i = '0;
  logic pkt_ready_n_o, switch_err_o, sop_err_o, pkt_mode_o;

  always #4 clk = ~clk;

  pkt_ready_tracker i_pkt_ready_tracker (.*);

  typedef struct { logic rdy_n, sw, dup; string tag; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  bit finished = 0;

  int mcnt [32];
  bit mopen [32];
  int mlast, msel;
  bit mmode;

  task automatic chk(logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic cyc(bit we, int wq, bit [3:0] mk, bit re, bit [3:0] rmk,
                     bit se, int sel, string tag);
    item_t it;
    bit done, dec;
    @(negedge clk);
    wr_en_i = we; wr_q_i = 5'(wq); wr_data_i = {mk, 32'hA5A5_0000 + 32'(wq)};
    rd_en_i = re; rd_data_i = {rmk, 32'h5A5A_FFFF};
    rd_sel_en_i = se; rd_sel_i = 5'(sel);
    it.rdy_n = !(mmode && mcnt[msel] != 0);
    it.sw    = mmode && we && wq != mlast && mopen[mlast];
    it.dup   = mmode && we && mk[0] && mopen[wq];
    it.tag   = tag;
    sb.push_back(it);
    if (mmode) begin
      done = we && mk[1] && (mopen[wq] || mk[0]);
      dec  = re && rmk[1] && mcnt[msel] > 0;
      if (!(done && dec && wq == msel)) begin
        if (done && mcnt[wq] < 255) mcnt[wq]++;
        if (dec) mcnt[msel]--;
      end
      if (we) begin
        if (mk[1]) mopen[wq] = 0;
        else if (mk[0]) mopen[wq] = 1;
      end
    end
    if (we) mlast = wq;
    if (se) msel = sel;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 0, 4'h0, 0, 0, tag);
  endtask

  task automatic do_reset(bit m, bit [1:0] cfg);
    idle(2, "settle");
    repeat (2) @(negedge clk);
    rst_n = 0; pkt_mode_i = m; port_cfg_i = cfg;
    wr_en_i = 0; rd_en_i = 0; rd_sel_en_i = 0;
    repeat (3) @(negedge clk);
    chk(pkt_ready_n_o, 1'b1, "R12 reset flag");
    chk(switch_err_o, 1'b0, "R12 reset switch_err");
    chk(sop_err_o, 1'b0, "R12 reset sop_err");
    chk(pkt_mode_o, m && cfg == 2'b00, "R1 R2 mode capture");
    rst_n = 1;
    pkt_mode_i = !m;
    mmode = m && cfg == 2'b00;
    for (int q = 0; q < 32; q++) begin mcnt[q] = 0; mopen[q] = 0; end
    mlast = 0; msel = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        chk(pkt_ready_n_o, it.rdy_n, {"R4 flag ", it.tag});
        chk(switch_err_o, it.sw, {"R5 switch_err ", it.tag});
        chk(sop_err_o, it.dup, {"R8 sop_err ", it.tag});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1, 2'b00);
    cyc(0, 0, 4'h0, 0, 4'h0, 1, 2, "R11 select q2");
    cyc(1, 2, 4'h1, 0, 4'h0, 0, 0, "R7 sop q2");
    cyc(1, 2, 4'h0, 0, 4'h0, 0, 0, "R7 body q2");
    cyc(1, 2, 4'h2, 0, 4'h0, 0, 0, "R7 eop q2");
    idle(2, "R4 latency");
    cyc(0, 0, 4'h0, 1, 4'h1, 0, 0, "R9 read sop");
    cyc(0, 0, 4'h0, 1, 4'h0, 0, 0, "R9 read body");
    cyc(0, 0, 4'h0, 1, 4'h2, 0, 0, "R9 read eop");
    cyc(0, 0, 4'h0, 1, 4'h2, 0, 0, "R9 read at zero");
    idle(2, "R9 drained");
    cyc(1, 5, 4'h3, 0, 4'h0, 0, 0, "R7 single word q5");
    cyc(1, 5, 4'h3, 1, 4'h2, 1, 5, "R11 select with read");
    idle(3, "R11 q5 ready");
    cyc(1, 5, 4'h3, 1, 4'h2, 0, 0, "R9 same cycle inc dec");
    idle(2, "R9 net zero");
    cyc(1, 7, 4'h1, 0, 4'h0, 0, 0, "R5 open q7");
    cyc(1, 8, 4'h0, 0, 4'h0, 0, 0, "R5 switch mid packet");
    cyc(1, 7, 4'h1, 0, 4'h0, 0, 0, "R8 doubled sop");
    cyc(1, 7, 4'h2, 0, 4'h0, 1, 7, "R8 close q7");
    idle(2, "R8 one packet");
    cyc(0, 0, 4'h0, 1, 4'h2, 0, 0, "R8 drain q7");
    idle(2, "R8 q7 empty");
    cyc(1, 9, 4'h2, 0, 4'h0, 1, 9, "R7 stray eop");
    cyc(1, 9, 4'hC, 0, 4'h0, 0, 0, "R3 upper bits only");
    cyc(1, 10, 4'h0, 0, 4'h0, 0, 0, "R3 switch after upper bits");
    idle(2, "R7 q9 empty");
    cyc(0, 0, 4'h0, 0, 4'h0, 1, 3, "R10 select q3");
    for (int i = 0; i < 256; i++) cyc(1, 3, 4'h3, 0, 4'h0, 0, 0, "R10 fill");
    idle(2, "R10 saturated");
    for (int i = 0; i < 254; i++) cyc(0, 0, 4'h0, 1, 4'hE, 0, 0, "R10 drain");
    idle(2, "R10 one left");
    cyc(0, 0, 4'h0, 1, 4'h2, 0, 0, "R10 last read");
    idle(2, "R10 empty");

    do_reset(0, 2'b00);
    cyc(0, 0, 4'h0, 0, 4'h0, 1, 4, "R6 select q4");
    cyc(1, 4, 4'h3, 0, 4'h0, 0, 0, "R6 packet ignored");
    cyc(1, 4, 4'h1, 0, 4'h0, 0, 0, "R6 sop ignored");
    cyc(1, 6, 4'h1, 0, 4'h0, 0, 0, "R6 switch ignored");
    idle(3, "R6 flag high");

    do_reset(1, 2'b01);
    cyc(1, 0, 4'h3, 0, 4'h0, 0, 0, "R2 refused width");
    idle(3, "R2 flag high");

    do_reset(1, 2'b00);
    cyc(1, 0, 4'h3, 0, 4'h0, 0, 0, "R1 mode input toggled");
    idle(3, "R1 still packet mode");
    chk(pkt_mode_o, 1'b1, "R1 mode held");

    idle(2, "end");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule